// File: doc/BRIEF.md
# Lifecycle transition sequencer

This block is the control state machine that walks one requested change of a device's lifecycle state through a fixed chain of steps. From idle, a request first switches the clock source and then bumps and programs a transition counter. It then confirms that the requested target is a legal successor of the current state and asks a hash agent to digest the unlock token. For a return-to-manufacturer target it also has a flash wipe carried out. It then compares the hashed token against a reference in two halves, and finally programs the new state. Counter programming, state programming, hashing and wiping are not done here: each is a request output answered by an ack input and, where a step can fail, an error input.

Every step that fails drops into a terminal "done" state and records a failed outcome. Only a clean final programming step records success. An idle-time scrap request parks the machine in a terminal scrap state. Either of two escalation inputs forces a terminal alarm state from anywhere except scrap. The state register holds sparse 16-bit codes that are at least four bit flips apart. Any illegal code decodes to a "bad" state, which always moves on to alarm. A fault-injection input flips bits of the register so that this hardening can be exercised.

Top module: `lct_fsm`

## Requirements
- R1: While `rst` is high at a clock edge the state becomes boot (`state_o` = 0) and both outcome flags clear. The first edge with `rst` low moves boot to idle (`state_o` = 1).
- R2: In idle (1), `trans_req_i` moves to clock switch (2) and takes priority over `scrap_req_i`. `scrap_req_i` alone moves to scrap (12). With neither, idle holds.
- R3: Clock switch (2) lasts one cycle and leads to counter check (3). Counter check goes to done (11) with a failed outcome when `cnt_i` equals `CNT_MAX`, and to counter write (4) otherwise. In counter write `prog_val_o` = `cnt_i` + 1.
- R4: Counter write (4), token hash (6), flash wipe (7) and state write (10) each hold until their agent's ack. An ack with `prog_err_i` in 4 or 10, or with `hash_err_i` in 6, goes to done (11) with a failed outcome.
- R5: Legality check (5) goes to token hash (6) only when `tgt_lc_i` > `cur_lc_i` and `tgt_lc_i` <= `LC_LAST`. Otherwise it goes to done with a failed outcome.
- R6: A hash ack without error latches `hash_i`. It goes to flash wipe (7) when `tgt_lc_i` equals `RMA_LC` and to first compare (8) otherwise. Flash wipe always proceeds to first compare on `rma_ack_i`.
- R7: First compare (8) checks the low half of the latched hash against `token_ref_i` and second compare (9) checks the high half. A mismatch goes to done with a failed outcome. Second compare holds while `tok_stall_i` is high.
- R8: A state-write ack without error enters done with `trans_ok_o` = 1. Every failure entry sets `trans_fail_o` = 1. The flags are never both high and keep their value until reset.
- R9: Done (11), scrap (12) and alarm (13) are left only by reset, except that done moves to alarm on escalation.
- R10: `esc_a_i` or `esc_b_i` high at an edge moves every state except scrap to alarm (13). This overrides every other condition.
- R11: Any register code outside the legal set decodes as bad (14), and bad always moves to alarm on the next edge. Flipping one to three register bits through `flip_i` gives bad on the next cycle.
- R12: The outputs decode the state. `prog_req_o` is high only in 4 and 10, `hash_req_o` in 6, and `rma_req_o` in 7. `busy_o` is high in 2 to 10 and `clk_sel_o` in 2 to 11. `scrapped_o` is high in 12 and `escalated_o` in 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esc_a_i | input | 1 | First escalation input |
| esc_b_i | input | 1 | Second escalation input |
| flip_i | input | 16 | Fault-injection XOR mask on the state register |
| trans_req_i | input | 1 | Start a transition (sampled in idle) |
| scrap_req_i | input | 1 | Scrap request (sampled in idle) |
| cur_lc_i | input | LCW | Current lifecycle state |
| tgt_lc_i | input | LCW | Requested target lifecycle state |
| cnt_i | input | CNTW | Current transition count |
| prog_ack_i | input | 1 | Programming agent done |
| prog_err_i | input | 1 | Programming agent error (valid with ack) |
| hash_ack_i | input | 1 | Hash agent done |
| hash_err_i | input | 1 | Hash agent error (valid with ack) |
| hash_i | input | HW | Token digest from the hash agent |
| token_ref_i | input | HW | Reference digest |
| tok_stall_i | input | 1 | Hold the second compare step |
| rma_ack_i | input | 1 | Flash wipe agent done |
| state_o | output | 4 | Decoded state index |
| clk_sel_o | output | 1 | Clock mux select |
| prog_req_o | output | 1 | Programming request |
| prog_val_o | output | max(CNTW,LCW) | Value to program |
| hash_req_o | output | 1 | Hash request |
| rma_req_o | output | 1 | Flash wipe request |
| busy_o | output | 1 | Transition in progress |
| trans_ok_o | output | 1 | Transition finished successfully |
| trans_fail_o | output | 1 | Transition failed |
| scrapped_o | output | 1 | In scrap |
| escalated_o | output | 1 | In alarm |

## Verification
A corrupted state register shows on `state_o` as bad (14) one cycle after the flip and as alarm (13) one cycle later. Every agent request drops in that same cycle. A wrong next-state choice moves `state_o` off the expected sequence on the very edge it is taken. The bench's cycle model therefore flags it at once, before a request or an outcome flag can diverge. A wrong outcome shows up as a mismatched `trans_ok_o`/`trans_fail_o` in the same cycle that done is entered.

// File: rtl/lct_pkg.sv
package lct_pkg;

  localparam int unsigned ST_REP = 4;
  localparam int unsigned ST_W   = 4 * ST_REP;
  localparam logic [ST_W-1:0] ST_MASK = ST_W'(64'h96E1_3C5A_A5C3_5A3C);

  typedef enum logic [3:0] {
    S_BOOT      = 4'd0,
    S_IDLE      = 4'd1,
    S_CLKSW     = 4'd2,
    S_CNT_BUMP  = 4'd3,
    S_CNT_WRITE = 4'd4,
    S_LEGAL_CHK = 4'd5,
    S_TOK_HASH  = 4'd6,
    S_RMA_WIPE  = 4'd7,
    S_TOK_CMP_A = 4'd8,
    S_TOK_CMP_B = 4'd9,
    S_LC_WRITE  = 4'd10,
    S_DONE      = 4'd11,
    S_SCRAP     = 4'd12,
    S_ALARM     = 4'd13,
    S_BAD       = 4'd14
  } lct_st_e;

  // Index replicated into every nibble, then scrambled: distinct codes differ in >= 4 bits.
  function automatic logic [ST_W-1:0] st_enc(input lct_st_e s);
    return {ST_REP{s}} ^ ST_MASK;
  endfunction

  function automatic lct_st_e st_dec(input logic [ST_W-1:0] code);
    logic [ST_W-1:0] raw;
    logic            ok;
    raw = code ^ ST_MASK;
    ok  = (raw[3:0] != 4'hF);
    for (int i = 1; i < ST_REP; i++) begin
      if (raw[4*i +: 4] != raw[3:0]) ok = 1'b0;
    end
    return ok ? lct_st_e'(raw[3:0]) : S_BAD;
  endfunction

endpackage

// File: rtl/lct_state_reg.sv
module lct_state_reg
  import lct_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  lct_st_e         nxt_i,
  input  logic [ST_W-1:0] flip_i,
  output lct_st_e         cur_o
);

  logic [ST_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= st_enc(S_BOOT);
    else     code_q <= st_enc(nxt_i) ^ flip_i;
  end

  assign cur_o = st_dec(code_q);

endmodule

// File: rtl/lct_next.sv
module lct_next
  import lct_pkg::*;
#(
  parameter int LCW     = 4,
  parameter int CNTW    = 5,
  parameter int LC_LAST = 10,
  parameter int RMA_LC  = 9,
  parameter int CNT_MAX = 24
) (
  input  lct_st_e         cur_i,
  input  logic            esc_a_i,
  input  logic            esc_b_i,
  input  logic            trans_req_i,
  input  logic            scrap_req_i,
  input  logic [LCW-1:0]  cur_lc_i,
  input  logic [LCW-1:0]  tgt_lc_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            prog_ack_i,
  input  logic            prog_err_i,
  input  logic            hash_ack_i,
  input  logic            hash_err_i,
  input  logic            rma_ack_i,
  input  logic            tok_stall_i,
  input  logic            match_lo_i,
  input  logic            match_hi_i,
  output lct_st_e         nxt_o,
  output logic            fail_o
);

  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(CNT_MAX);
  localparam logic [LCW-1:0]  TGT_TOP = LCW'(LC_LAST);
  localparam logic [LCW-1:0]  TGT_RMA = LCW'(RMA_LC);

  logic legal;
  assign legal = (tgt_lc_i > cur_lc_i) && (tgt_lc_i <= TGT_TOP);

  always_comb begin
    nxt_o  = cur_i;
    fail_o = 1'b0;
    if (cur_i == S_BAD) begin
      nxt_o = S_ALARM;
    end else if ((esc_a_i || esc_b_i) && cur_i != S_SCRAP) begin
      nxt_o = S_ALARM;
    end else begin
      case (cur_i)
        S_BOOT:  nxt_o = S_IDLE;
        S_IDLE: begin
          if (trans_req_i)      nxt_o = S_CLKSW;
          else if (scrap_req_i) nxt_o = S_SCRAP;
        end
        S_CLKSW: nxt_o = S_CNT_BUMP;
        S_CNT_BUMP: begin
          if (cnt_i == CNT_TOP) begin nxt_o = S_DONE; fail_o = 1'b1; end
          else nxt_o = S_CNT_WRITE;
        end
        S_CNT_WRITE: begin
          if (prog_ack_i) begin
            nxt_o  = prog_err_i ? S_DONE : S_LEGAL_CHK;
            fail_o = prog_err_i;
          end
        end
        S_LEGAL_CHK: begin
          if (legal) nxt_o = S_TOK_HASH;
          else begin nxt_o = S_DONE; fail_o = 1'b1; end
        end
        S_TOK_HASH: begin
          if (hash_ack_i) begin
            if (hash_err_i) begin nxt_o = S_DONE; fail_o = 1'b1; end
            else nxt_o = (tgt_lc_i == TGT_RMA) ? S_RMA_WIPE : S_TOK_CMP_A;
          end
        end
        S_RMA_WIPE: if (rma_ack_i) nxt_o = S_TOK_CMP_A;
        S_TOK_CMP_A: begin
          if (match_lo_i) nxt_o = S_TOK_CMP_B;
          else begin nxt_o = S_DONE; fail_o = 1'b1; end
        end
        S_TOK_CMP_B: begin
          if (!tok_stall_i) begin
            if (match_hi_i) nxt_o = S_LC_WRITE;
            else begin nxt_o = S_DONE; fail_o = 1'b1; end
          end
        end
        S_LC_WRITE: begin
          if (prog_ack_i) begin nxt_o = S_DONE; fail_o = prog_err_i; end
        end
        S_DONE, S_SCRAP, S_ALARM: nxt_o = cur_i;
        default: nxt_o = S_ALARM;
      endcase
    end
  end

endmodule

// File: rtl/lct_datapath.sv
module lct_datapath
  import lct_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  lct_st_e       cur_i,
  input  lct_st_e       nxt_i,
  input  logic          fail_i,
  input  logic          hash_ack_i,
  input  logic          hash_err_i,
  input  logic [HW-1:0] hash_i,
  input  logic [HW-1:0] token_ref_i,
  output logic          match_lo_o,
  output logic          match_hi_o,
  output logic          ok_o,
  output logic          fail_o
);

  localparam int HH = HW / 2;

  logic [HW-1:0] hash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_q <= '0;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      if (cur_i == S_TOK_HASH && hash_ack_i && !hash_err_i) hash_q <= hash_i;
      if (nxt_i == S_DONE && cur_i != S_DONE) begin
        ok_o   <= !fail_i;
        fail_o <= fail_i;
      end
    end
  end

  assign match_lo_o = (hash_q[HH-1:0]  == token_ref_i[HH-1:0]);
  assign match_hi_o = (hash_q[HW-1:HH] == token_ref_i[HW-1:HH]);

endmodule

// File: rtl/lct_fsm.sv
module lct_fsm
  import lct_pkg::*;
#(
  parameter int LCW     = 4,
  parameter int CNTW    = 5,
  parameter int HW      = 32,
  parameter int LC_LAST = 10,
  parameter int RMA_LC  = 9,
  parameter int CNT_MAX = 24,
  localparam int PVW    = (CNTW > LCW) ? CNTW : LCW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            esc_a_i,
  input  logic            esc_b_i,
  input  logic [ST_W-1:0] flip_i,
  input  logic            trans_req_i,
  input  logic            scrap_req_i,
  input  logic [LCW-1:0]  cur_lc_i,
  input  logic [LCW-1:0]  tgt_lc_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            prog_ack_i,
  input  logic            prog_err_i,
  input  logic            hash_ack_i,
  input  logic            hash_err_i,
  input  logic [HW-1:0]   hash_i,
  input  logic [HW-1:0]   token_ref_i,
  input  logic            tok_stall_i,
  input  logic            rma_ack_i,
  output logic [3:0]      state_o,
  output logic            clk_sel_o,
  output logic            prog_req_o,
  output logic [PVW-1:0]  prog_val_o,
  output logic            hash_req_o,
  output logic            rma_req_o,
  output logic            busy_o,
  output logic            trans_ok_o,
  output logic            trans_fail_o,
  output logic            scrapped_o,
  output logic            escalated_o
);

  lct_st_e cur, nxt;
  logic    fail_path, match_lo, match_hi;

  lct_state_reg u_state (
    .clk(clk), .rst(rst), .nxt_i(nxt), .flip_i(flip_i), .cur_o(cur)
  );

  lct_next #(
    .LCW(LCW), .CNTW(CNTW), .LC_LAST(LC_LAST), .RMA_LC(RMA_LC), .CNT_MAX(CNT_MAX)
  ) u_next (
    .cur_i(cur), .esc_a_i(esc_a_i), .esc_b_i(esc_b_i),
    .trans_req_i(trans_req_i), .scrap_req_i(scrap_req_i),
    .cur_lc_i(cur_lc_i), .tgt_lc_i(tgt_lc_i), .cnt_i(cnt_i),
    .prog_ack_i(prog_ack_i), .prog_err_i(prog_err_i),
    .hash_ack_i(hash_ack_i), .hash_err_i(hash_err_i),
    .rma_ack_i(rma_ack_i), .tok_stall_i(tok_stall_i),
    .match_lo_i(match_lo), .match_hi_i(match_hi),
    .nxt_o(nxt), .fail_o(fail_path)
  );

  lct_datapath #(.HW(HW)) u_dp (
    .clk(clk), .rst(rst), .cur_i(cur), .nxt_i(nxt), .fail_i(fail_path),
    .hash_ack_i(hash_ack_i), .hash_err_i(hash_err_i), .hash_i(hash_i),
    .token_ref_i(token_ref_i), .match_lo_o(match_lo), .match_hi_o(match_hi),
    .ok_o(trans_ok_o), .fail_o(trans_fail_o)
  );

  assign state_o     = cur;
  assign prog_req_o  = (cur == S_CNT_WRITE) || (cur == S_LC_WRITE);
  assign prog_val_o  = (cur == S_CNT_WRITE) ? PVW'(cnt_i) + PVW'(1) : PVW'(tgt_lc_i);
  assign hash_req_o  = (cur == S_TOK_HASH);
  assign rma_req_o   = (cur == S_RMA_WIPE);
  assign busy_o      = (cur >= S_CLKSW) && (cur <= S_LC_WRITE);
  assign clk_sel_o   = busy_o || (cur == S_DONE);
  assign scrapped_o  = (cur == S_SCRAP);
  assign escalated_o = (cur == S_ALARM);

endmodule

// File: rtl/lct_fsm_chk.sv
module lct_fsm_chk
  import lct_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            esc_a_i,
  input logic            esc_b_i,
  input logic [ST_W-1:0] flip_i,
  input logic [3:0]      state_o,
  input logic            prog_req_o,
  input logic            hash_req_o,
  input logic            rma_req_o,
  input logic            trans_ok_o,
  input logic            trans_fail_o
);

  logic esc;
  assign esc = esc_a_i || esc_b_i;

  AST_BAD_TO_ALARM: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd14) |=> (state_o == 4'd13)); // R11

  AST_FLIP_CAUGHT: assert property (@(posedge clk) disable iff (rst)
    (flip_i != '0 && $countones(flip_i) < 4) |=> (state_o == 4'd14)); // R11

  AST_ESC_TAKES_OVER: assert property (@(posedge clk) disable iff (rst)
    (esc && state_o != 4'd12 && flip_i == '0) |=> (state_o == 4'd13)); // R10

  AST_TERMINAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 4'd11 || state_o == 4'd12 || state_o == 4'd13) && !esc && flip_i == '0)
    |=> $stable(state_o)); // R9

  AST_CLKSW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd2 && !esc && flip_i == '0) |=> (state_o == 4'd3)); // R3

  AST_ONE_AGENT_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req_o, hash_req_o, rma_req_o})); // R12

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(trans_ok_o && trans_fail_o)); // R8

endmodule

bind lct_fsm lct_fsm_chk u_chk (
  .clk(clk), .rst(rst), .esc_a_i(esc_a_i), .esc_b_i(esc_b_i), .flip_i(flip_i),
  .state_o(state_o), .prog_req_o(prog_req_o), .hash_req_o(hash_req_o),
  .rma_req_o(rma_req_o), .trans_ok_o(trans_ok_o), .trans_fail_o(trans_fail_o)
);

// File: tb/lct_fsm_tb.sv
module lct_fsm_tb;
  import lct_pkg::*;

  localparam int LCW = 4, CNTW = 5, HW = 32, LC_LAST = 10, RMA_LC = 9, CNT_MAX = 24;
  localparam int PVW = (CNTW > LCW) ? CNTW : LCW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, esc_a_i = 0, esc_b_i = 0, trans_req_i = 0, scrap_req_i = 0;
  logic [ST_W-1:0] flip_i = '0;
  logic [LCW-1:0] cur_lc_i = '0, tgt_lc_i = '0;
  logic [CNTW-1:0] cnt_i = '0;
  logic prog_ack_i = 0, prog_err_i = 0, hash_ack_i = 0, hash_err_i = 0, tok_stall_i = 0, rma_ack_i = 0;
  logic [HW-1:0] hash_i = '0, token_ref_i = '0;
  logic [3:0] state_o;
  logic clk_sel_o, prog_req_o, hash_req_o, rma_req_o, busy_o, trans_ok_o, trans_fail_o;
  logic scrapped_o, escalated_o;
  logic [PVW-1:0] prog_val_o;

  lct_fsm #(.LCW(LCW), .CNTW(CNTW), .HW(HW), .LC_LAST(LC_LAST), .RMA_LC(RMA_LC),
            .CNT_MAX(CNT_MAX)) u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  int ms = 0;
  logic [HW-1:0] mh = '0;
  bit mok = 0, mfail = 0, mon = 0;

  always @(posedge clk) begin : ref_model
    int n;
    bit f;
    n = ms; f = 0;
    if (rst) begin
      ms = 0; mh = '0; mok = 0; mfail = 0; mon = 1;
    end else begin
      if (ms == 14) n = 13;
      else if ((esc_a_i || esc_b_i) && ms != 12) n = 13;
      else begin
        case (ms)
          0: n = 1;
          1: n = trans_req_i ? 2 : (scrap_req_i ? 12 : 1);
          2: n = 3;
          3: if (cnt_i == CNT_MAX) begin n = 11; f = 1; end else n = 4;
          4: if (prog_ack_i) begin n = prog_err_i ? 11 : 5; f = prog_err_i; end
          5: if (tgt_lc_i > cur_lc_i && tgt_lc_i <= LC_LAST) n = 6; else begin n = 11; f = 1; end
          6: if (hash_ack_i) begin
               if (hash_err_i) begin n = 11; f = 1; end
               else begin mh = hash_i; n = (tgt_lc_i == RMA_LC) ? 7 : 8; end
             end
          7: if (rma_ack_i) n = 8;
          8: if (mh[15:0] == token_ref_i[15:0]) n = 9; else begin n = 11; f = 1; end
          9: if (!tok_stall_i) begin
               if (mh[31:16] == token_ref_i[31:16]) n = 10; else begin n = 11; f = 1; end
             end
          10: if (prog_ack_i) begin n = 11; f = prog_err_i; end
          default: n = ms;
        endcase
      end
      if (n == 11 && ms != 11) begin mok = !f; mfail = f; end
      ms = (flip_i != '0) ? 14 : n;
    end
  end

  task automatic ck(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit pr, br, cs;
    pr = (ms == 4 || ms == 10);
    br = (ms >= 2 && ms <= 10);
    cs = (ms >= 2 && ms <= 11);
    ck(state_o == ms, "state", state_o, ms);
    ck(prog_req_o == pr, "R12 prog_req", prog_req_o, pr);
    ck(hash_req_o == (ms == 6), "R12 hash_req", hash_req_o, ms == 6);
    ck(rma_req_o == (ms == 7), "R12 rma_req", rma_req_o, ms == 7);
    ck(busy_o == br, "R12 busy", busy_o, br);
    ck(clk_sel_o == cs, "R12 clk_sel", clk_sel_o, cs);
    ck(scrapped_o == (ms == 12), "R12 scrapped", scrapped_o, ms == 12);
    ck(escalated_o == (ms == 13), "R12 escalated", escalated_o, ms == 13);
    ck(trans_ok_o == mok, "R8 ok", trans_ok_o, mok);
    ck(trans_fail_o == mfail, "R8 fail", trans_fail_o, mfail);
    if (ms == 4) ck(prog_val_o == PVW'(cnt_i + 1), "R3 prog_val", prog_val_o, cnt_i + 1);
    if (ms == 10) ck(prog_val_o == PVW'(tgt_lc_i), "R4 prog_val", prog_val_o, tgt_lc_i);
  endtask

  // agent and event configuration
  int p_delay = 0, h_delay = 0, r_delay = 0, stall_n = 0;
  int pcnt = 0, hcnt = 0, rcnt = 0, scnt = 0;
  bit err_cnt = 0, err_lc = 0, err_hash = 0;
  int ev_kind = 0, ev_state = 0, ev_bit = 0;
  bit saw_rma = 0, saw_cntw = 0, saw_cmpb = 0;
  int cmpb_cycles = 0;

  task automatic tick();
    @(posedge clk); #2;
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (mon && !rst) compare_all();
    if (state_o == 4'd7) saw_rma = 1;
    if (state_o == 4'd4) saw_cntw = 1;
    if (state_o == 4'd9) begin saw_cmpb = 1; cmpb_cycles++; end
    prog_ack_i = 0; hash_ack_i = 0; rma_ack_i = 0;
    if (prog_req_o) begin
      if (pcnt > 0) pcnt--; else prog_ack_i = 1;
      prog_err_i = (state_o == 4'd4) ? err_cnt : err_lc;
    end else pcnt = p_delay;
    if (hash_req_o) begin
      if (hcnt > 0) hcnt--; else hash_ack_i = 1;
      hash_err_i = err_hash;
    end else hcnt = h_delay;
    if (rma_req_o) begin
      if (rcnt > 0) rcnt--; else rma_ack_i = 1;
    end else rcnt = r_delay;
    tok_stall_i = 0;
    if (state_o == 4'd9) begin
      if (scnt > 0) begin tok_stall_i = 1; scnt--; end
    end else scnt = stall_n;
    esc_a_i = 0; esc_b_i = 0; flip_i = '0;
    if (ev_kind != 0 && state_o == 4'(ev_state)) begin
      case (ev_kind)
        1: esc_a_i = 1;
        2: esc_b_i = 1;
        default: flip_i = ST_W'(1) << ev_bit;
      endcase
      ev_kind = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1; trans_req_i = 0; scrap_req_i = 0;
    p_delay = 0; h_delay = 0; r_delay = 0; stall_n = 0;
    err_cnt = 0; err_lc = 0; err_hash = 0; ev_kind = 0;
    saw_rma = 0; saw_cntw = 0; saw_cmpb = 0; cmpb_cycles = 0;
    tick(); tick();
    rst = 0;
    tick();
  endtask

  task automatic run_trans(input int cur, input int tgt, input int cnt,
                           input logic [HW-1:0] h, input logic [HW-1:0] r);
    cur_lc_i = LCW'(cur); tgt_lc_i = LCW'(tgt); cnt_i = CNTW'(cnt);
    hash_i = h; token_ref_i = r;
    trans_req_i = 1; tick(); trans_req_i = 0;
    for (int i = 0; i < 80; i++) begin
      if (state_o == 4'd11 || state_o == 4'd12 || state_o == 4'd13) break;
      tick();
    end
  endtask

  localparam logic [HW-1:0] HV = 32'hC0DE_1234;

  initial begin
    // R1 reset state and release
    tag = "R1";
    rst = 1; tick(); tick();
    ck(state_o == 4'd0, "R1 boot in reset", state_o, 0);
    ck(busy_o == 0 && prog_req_o == 0, "R1 outputs idle", busy_o, 0);
    rst = 0; tick();
    ck(state_o == 4'd1, "R1 idle after boot", state_o, 1);

    // R8 clean transition, no wipe
    tag = "R8";
    run_trans(2, 5, 3, HV, HV);
    ck(trans_ok_o == 1, "R8 success flag", trans_ok_o, 1);
    ck(saw_cntw == 1, "R3 counter write visited", saw_cntw, 1);
    ck(saw_rma == 0, "R6 no wipe for plain target", saw_rma, 0);
    tag = "R9";
    trans_req_i = 1; for (int i = 0; i < 4; i++) tick(); trans_req_i = 0;
    ck(state_o == 4'd11, "R9 done sticky", state_o, 11);

    // R4 agent waits
    do_reset(); tag = "R4"; p_delay = 3; h_delay = 2;
    run_trans(1, 4, 0, HV, HV);
    ck(trans_ok_o == 1, "R4 success after waits", trans_ok_o, 1);

    // R6 wipe branch
    do_reset(); tag = "R6"; r_delay = 2;
    run_trans(2, RMA_LC, 5, HV, HV);
    ck(saw_rma == 1, "R6 wipe visited", saw_rma, 1);
    ck(trans_ok_o == 1, "R6 success", trans_ok_o, 1);

    // R3 counter saturated
    do_reset(); tag = "R3";
    run_trans(2, 5, CNT_MAX, HV, HV);
    ck(trans_fail_o == 1, "R3 fail at max count", trans_fail_o, 1);
    ck(saw_cntw == 0, "R3 no counter write", saw_cntw, 0);

    // R5 legality
    do_reset(); tag = "R5";
    run_trans(3, 3, 1, HV, HV);
    ck(trans_fail_o == 1, "R5 same target rejected", trans_fail_o, 1);
    do_reset();
    run_trans(3, LC_LAST + 1, 1, HV, HV);
    ck(trans_fail_o == 1, "R5 target past last rejected", trans_fail_o, 1);
    do_reset();
    run_trans(3, LC_LAST, 1, HV, HV);
    ck(trans_ok_o == 1, "R5 last target accepted", trans_ok_o, 1);

    // R4 agent errors
    do_reset(); tag = "R4"; err_cnt = 1;
    run_trans(1, 2, 1, HV, HV);
    ck(trans_fail_o == 1, "R4 counter write error", trans_fail_o, 1);
    do_reset(); err_hash = 1;
    run_trans(1, 2, 1, HV, HV);
    ck(trans_fail_o == 1, "R4 hash error", trans_fail_o, 1);
    do_reset(); err_lc = 1;
    run_trans(1, 2, 1, HV, HV);
    ck(trans_fail_o == 1 && trans_ok_o == 0, "R4 state write error", trans_fail_o, 1);

    // R7 token compare
    do_reset(); tag = "R7";
    run_trans(1, 2, 1, HV, HV ^ 32'h0000_0001);
    ck(trans_fail_o == 1 && saw_cmpb == 0, "R7 low half mismatch", trans_fail_o, 1);
    do_reset();
    run_trans(1, 2, 1, HV, HV ^ 32'h8000_0000);
    ck(trans_fail_o == 1 && saw_cmpb == 1, "R7 high half mismatch", trans_fail_o, 1);
    do_reset(); stall_n = 3;
    run_trans(1, 2, 1, HV, HV);
    ck(cmpb_cycles == 4, "R7 stall holds second compare", cmpb_cycles, 4);
    ck(trans_ok_o == 1, "R7 success after stall", trans_ok_o, 1);

    // R2 idle choices
    do_reset(); tag = "R2";
    scrap_req_i = 1; tick(); scrap_req_i = 0;
    ck(state_o == 4'd12, "R2 scrap from idle", state_o, 12);
    tag = "R10";
    trans_req_i = 1; esc_a_i = 1; tick(); tick(); trans_req_i = 0;
    ck(state_o == 4'd12, "R10 scrap ignores escalation", state_o, 12);
    do_reset(); tag = "R2";
    scrap_req_i = 1; trans_req_i = 1; tick(); scrap_req_i = 0; trans_req_i = 0;
    ck(state_o == 4'd2, "R2 transition wins over scrap", state_o, 2);

    // R10 escalation
    do_reset(); tag = "R10";
    esc_a_i = 1; tick();
    ck(state_o == 4'd13, "R10 esc_a from idle", state_o, 13);
    tag = "R9";
    trans_req_i = 1; for (int i = 0; i < 4; i++) tick(); trans_req_i = 0;
    ck(state_o == 4'd13, "R9 alarm sticky", state_o, 13);
    do_reset(); tag = "R10"; h_delay = 5; ev_kind = 2; ev_state = 6;
    run_trans(1, 2, 1, HV, HV);
    ck(state_o == 4'd13 && trans_ok_o == 0, "R10 esc_b mid transition", state_o, 13);
    do_reset();
    run_trans(1, 2, 1, HV, HV);
    esc_b_i = 1; tick();
    ck(state_o == 4'd13, "R10 escalation leaves done", state_o, 13);

    // R11 bit flips
    tag = "R11";
    for (int b = 0; b < 16; b += 5) begin
      do_reset();
      ev_kind = 3; ev_state = 1; ev_bit = b;
      tick();
      tick();
      ck(state_o == 4'd14, "R11 flip decodes bad", state_o, 14);
      tick();
      ck(state_o == 4'd13, "R11 bad goes to alarm", state_o, 13);
    end
    do_reset(); p_delay = 20; ev_kind = 3; ev_state = 4; ev_bit = 15;
    run_trans(1, 2, 1, HV, HV);
    ck(state_o == 4'd13, "R11 flip during counter write", state_o, 13);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule